// File: doc/BRIEF.md
# Framed Command Byte Parser with Test Register Target

This block sits behind a serial byte receiver. It takes one byte per valid strobe and assembles framed commands from them. Every frame opens with a start byte and must close with an end byte in the slot its opcode expects. The parser decodes three commands: a soft reset, a register read and a register write. A read or a write leads to one single-cycle access on an internal register bus, which carries a core select, an 8-bit address, a 32-bit write value and a write flag.

A small test target sits on that bus. It holds two fixed identification words, a 32-bit scratch register and a register that drives an 8-bit debug output. Reads return their data through a one-cycle valid pulse. The access strobe and its fields are also brought out as ports, so an external observer can follow every bus transaction. Any frame that is malformed is dropped and has no side effect.

Top module: `frame_cmd_top`

## Requirements
- R1: While no frame is open, any byte other than 0x55 is dropped. It causes no access, no soft reset and no read-valid pulse.
- R2: The frame 0x55, 0x01, 0xAA raises `soft_rst_o` for exactly one cycle, the cycle after the 0xAA byte is accepted. In the following cycle the scratch register returns to 0x11223344 and the debug output returns to 0x00.
- R3: The frame 0x55, 0x10, sel, addr, 0xAA raises `acc_strobe_o` for one cycle, the cycle after 0xAA, with `acc_we_o`=0, `acc_sel_o`=sel and `acc_addr_o`=addr.
- R4: The frame 0x55, 0x11, sel, addr, d3, d2, d1, d0, 0xAA raises `acc_strobe_o` for one cycle with `acc_we_o`=1 and `acc_wdata_o`={d3,d2,d1,d0}. The first data byte received is the most significant byte.
- R5: A read access is followed one cycle later by a one-cycle `rd_valid_o` pulse, with `rd_data_o` carrying the read value. No other cycle has `rd_valid_o` high.
- R6: With select 0x01, address 0x00 reads 0x6672616D and address 0x01 reads 0x00010002.
- R7: With select 0x01, address 0x10 is a 32-bit read/write register. It reads 0x11223344 after reset.
- R8: With select 0x01, a write to address 0x20 stores the low 8 bits. Those bits drive `dbg_o` from the cycle after the access, and the register reads back zero-extended.
- R9: If the byte in the end slot is not 0xAA, the frame is dropped. No access and no soft reset follow.
- R10: An opcode other than 0x01, 0x10 or 0x11 drops the frame and makes the parser wait for a new 0x55.
- R11: A read with a select other than 0x01, or with an unmapped address, returns 0 with a normal read-valid pulse. A write to such a target changes neither `dbg_o` nor any later read value.
- R12: Bytes presented while `rx_valid_i` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| acc_strobe_o | output | 1 | Single-cycle bus access |
| acc_we_o | output | 1 | Access is a write |
| acc_sel_o | output | 8 | Core select of the access |
| acc_addr_o | output | 8 | Register address of the access |
| acc_wdata_o | output | 32 | Write value of the access |
| soft_rst_o | output | 1 | Soft reset pulse from a reset frame |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | 32 | Read data |
| dbg_o | output | 8 | Debug register output |

## Verification
When the closing byte is accepted on a clock edge, the access strobe or the soft-reset pulse appears after that same edge. The read-valid pulse and the debug-output update appear one edge later. The bench drives inputs and samples outputs on falling edges, and it records every strobe, pulse and read value as it occurs. After each frame it waits three falling edges and then compares the recorded event counts and fields with a model of the target kept in the bench. On every falling edge it also checks that a read-valid pulse is present exactly when a read strobe was seen on the previous falling edge.

// File: rtl/frmp_pkg.sv
package frmp_pkg;

   localparam logic [7:0] SOF_BYTE  = 8'h55;
   localparam logic [7:0] EOF_BYTE  = 8'hAA;
   localparam logic [7:0] OPC_RESET = 8'h01;
   localparam logic [7:0] OPC_READ  = 8'h10;
   localparam logic [7:0] OPC_WRITE = 8'h11;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_OPC,
      PS_SEL,
      PS_ADDR,
      PS_DATA,
      PS_END
   } pstate_t;

   typedef enum logic [1:0] {
      OPK_RESET,
      OPK_READ,
      OPK_WRITE
   } opkind_t;

endpackage

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
   import frmp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_byte_i,
   output logic              acc_strobe_o,
   output logic              acc_we_o,
   output logic [SEL_W-1:0]  acc_sel_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [DATA_W-1:0] acc_wdata_o,
   output logic              soft_rst_o
);

   localparam int NBYTES = DATA_W / 8;
   localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NBYTES - 1);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be a positive multiple of 8");
   end
   if (SEL_W > 8 || ADDR_W > 8) begin : g_bad_field_w
      $error("SEL_W and ADDR_W must fit in one byte");
   end

   pstate_t           state_q;
   opkind_t           op_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SEL_W-1:0]  sel_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              shift_en;

   assign shift_en = rx_valid_i && (state_q == PS_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= PS_IDLE;
         op_q         <= OPK_RESET;
         cnt_q        <= '0;
         sel_q        <= '0;
         addr_q       <= '0;
         acc_strobe_o <= 1'b0;
         acc_we_o     <= 1'b0;
         soft_rst_o   <= 1'b0;
      end else begin
         acc_strobe_o <= 1'b0;
         acc_we_o     <= 1'b0;
         soft_rst_o   <= 1'b0;
         if (rx_valid_i) begin
            case (state_q)
               PS_IDLE: begin
                  if (rx_byte_i == SOF_BYTE) state_q <= PS_OPC;
               end
               PS_OPC: begin
                  case (rx_byte_i)
                     OPC_RESET: begin
                        op_q    <= OPK_RESET;
                        state_q <= PS_END;
                     end
                     OPC_READ: begin
                        op_q    <= OPK_READ;
                        state_q <= PS_SEL;
                     end
                     OPC_WRITE: begin
                        op_q    <= OPK_WRITE;
                        state_q <= PS_SEL;
                     end
                     default: state_q <= PS_IDLE;
                  endcase
               end
               PS_SEL: begin
                  sel_q   <= rx_byte_i[SEL_W-1:0];
                  state_q <= PS_ADDR;
               end
               PS_ADDR: begin
                  addr_q <= rx_byte_i[ADDR_W-1:0];
                  cnt_q  <= '0;
                  state_q <= (op_q == OPK_WRITE) ? PS_DATA : PS_END;
               end
               PS_DATA: begin
                  if (cnt_q == LAST_IDX) state_q <= PS_END;
                  else cnt_q <= cnt_q + 1'b1;
               end
               PS_END: begin
                  state_q <= PS_IDLE;
                  if (rx_byte_i == EOF_BYTE) begin
                     if (op_q == OPK_RESET) begin
                        soft_rst_o <= 1'b1;
                     end else begin
                        acc_strobe_o <= 1'b1;
                        acc_we_o     <= (op_q == OPK_WRITE);
                     end
                  end
               end
               default: state_q <= PS_IDLE;
            endcase
         end
      end
   end

   // Data assembly: first byte lands in the top byte lane
   if (NBYTES == 1) begin : g_data_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        data_q <= '0;
         else if (shift_en) data_q <= rx_byte_i;
      end
   end else begin : g_data_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        data_q <= '0;
         else if (shift_en) data_q <= {data_q[DATA_W-9:0], rx_byte_i};
      end
   end

   assign acc_sel_o   = sel_q;
   assign acc_addr_o  = addr_q;
   assign acc_wdata_o = data_q;

   // R3 R4: access lasts one cycle
   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_strobe_o |=> !acc_strobe_o);

   // R9: an access or a soft reset needs an accepted end byte on the previous edge
   assert_end_byte_seen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_strobe_o || soft_rst_o) |-> $past(rx_valid_i && rx_byte_i == EOF_BYTE));

   // R2: soft reset lasts one cycle and never coincides with an access
   assert_soft_rst_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> !acc_strobe_o ##1 !soft_rst_o);

   // R12: no accepted byte, no event
   assert_no_valid_no_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rx_valid_i) |-> !(acc_strobe_o || soft_rst_o));

endmodule

// File: rtl/frame_test_target.sv
module frame_test_target #(
   parameter int              DATA_W   = 32,
   parameter int              SEL_W    = 8,
   parameter int              ADDR_W   = 8,
   parameter int              DBG_W    = 8,
   parameter int              MY_SEL   = 1,
   parameter int              A_ID0    = 'h00,
   parameter int              A_ID1    = 'h01,
   parameter int              A_SCR    = 'h10,
   parameter int              A_DBG    = 'h20,
   parameter logic [DATA_W-1:0] ID0_VAL  = 32'h6672_616D,
   parameter logic [DATA_W-1:0] ID1_VAL  = 32'h0001_0002,
   parameter logic [DATA_W-1:0] SCR_INIT = 32'h1122_3344
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst_i,
   input  logic              acc_strobe_i,
   input  logic              acc_we_i,
   input  logic [SEL_W-1:0]  acc_sel_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic [DATA_W-1:0] acc_wdata_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DBG_W-1:0]  dbg_o
);

   if (DBG_W > DATA_W || DBG_W < 1) begin : g_bad_dbg_w
      $error("DBG_W must lie between 1 and DATA_W");
   end

   localparam logic [SEL_W-1:0]  SEL_ME  = SEL_W'(MY_SEL);
   localparam logic [ADDR_W-1:0] AD_ID0  = ADDR_W'(A_ID0);
   localparam logic [ADDR_W-1:0] AD_ID1  = ADDR_W'(A_ID1);
   localparam logic [ADDR_W-1:0] AD_SCR  = ADDR_W'(A_SCR);
   localparam logic [ADDR_W-1:0] AD_DBG  = ADDR_W'(A_DBG);

   logic [DATA_W-1:0] scr_q;
   logic [DBG_W-1:0]  dbg_q;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] dbg_ext;
   logic              hit;
   logic              wr_hit;

   assign hit    = acc_strobe_i && (acc_sel_i == SEL_ME);
   assign wr_hit = hit && acc_we_i;

   if (DBG_W == DATA_W) begin : g_dbg_full
      assign dbg_ext = dbg_q;
   end else begin : g_dbg_ext
      assign dbg_ext = {{(DATA_W-DBG_W){1'b0}}, dbg_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scr_q <= SCR_INIT;
         dbg_q <= '0;
      end else if (soft_rst_i) begin
         scr_q <= SCR_INIT;
         dbg_q <= '0;
      end else if (wr_hit) begin
         if (acc_addr_i == AD_SCR) scr_q <= acc_wdata_i;
         if (acc_addr_i == AD_DBG) dbg_q <= acc_wdata_i[DBG_W-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (acc_sel_i == SEL_ME) begin
         if (acc_addr_i == AD_ID0)      rd_mux = ID0_VAL;
         else if (acc_addr_i == AD_ID1) rd_mux = ID1_VAL;
         else if (acc_addr_i == AD_SCR) rd_mux = scr_q;
         else if (acc_addr_i == AD_DBG) rd_mux = dbg_ext;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= acc_strobe_i && !acc_we_i;
         if (acc_strobe_i && !acc_we_i) rd_data_o <= rd_mux;
      end
   end

   assign dbg_o = dbg_q;

   // R5: read-valid follows a read access by exactly one cycle
   assert_rd_valid_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> $past(acc_strobe_i && !acc_we_i));

   // R2: soft reset restores the registers
   assert_soft_rst_restores_R2: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_i |=> (scr_q == SCR_INIT) && (dbg_q == '0));

   // R8 R11: the debug output moves only after a matching write or a soft reset
   assert_dbg_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(soft_rst_i) && !$past(wr_hit && acc_addr_i == AD_DBG) |-> $stable(dbg_o));

   // R11: a write to another select leaves the scratch register alone
   assert_foreign_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(acc_strobe_i && acc_sel_i != SEL_ME) && !$past(soft_rst_i) |-> $stable(scr_q));

endmodule

// File: rtl/frame_cmd_top.sv
module frame_cmd_top #(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 8,
   parameter int ADDR_W = 8,
   parameter int DBG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_byte_i,
   output logic              acc_strobe_o,
   output logic              acc_we_o,
   output logic [SEL_W-1:0]  acc_sel_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic [DATA_W-1:0] acc_wdata_o,
   output logic              soft_rst_o,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DBG_W-1:0]  dbg_o
);

   cmd_frame_parser #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .ADDR_W (ADDR_W)
   ) parser_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_valid_i   (rx_valid_i),
      .rx_byte_i    (rx_byte_i),
      .acc_strobe_o (acc_strobe_o),
      .acc_we_o     (acc_we_o),
      .acc_sel_o    (acc_sel_o),
      .acc_addr_o   (acc_addr_o),
      .acc_wdata_o  (acc_wdata_o),
      .soft_rst_o   (soft_rst_o)
   );

   frame_test_target #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .ADDR_W (ADDR_W),
      .DBG_W  (DBG_W)
   ) target_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst_i   (soft_rst_o),
      .acc_strobe_i (acc_strobe_o),
      .acc_we_i     (acc_we_o),
      .acc_sel_i    (acc_sel_o),
      .acc_addr_i   (acc_addr_o),
      .acc_wdata_i  (acc_wdata_o),
      .rd_valid_o   (rd_valid_o),
      .rd_data_o    (rd_data_o),
      .dbg_o        (dbg_o)
   );

endmodule

// File: tb/frame_cmd_top_tb.sv
`timescale 1ns/1ps
module frame_cmd_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        acc_strobe, acc_we, soft_rst, rd_valid;
   logic [7:0]  acc_sel, acc_addr, dbg;
   logic [31:0] acc_wdata, rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int          n_acc = 0, n_soft = 0, n_rd = 0;
   logic        last_we;
   logic [7:0]  last_sel, last_addr;
   logic [31:0] last_wdata, last_rd;
   logic        prev_rd_strobe = 1'b0;

   logic [31:0] m_scr = 32'h1122_3344;
   logic [7:0]  m_dbg = 8'h00;

   always #2 clk = ~clk;

   frame_cmd_top dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
      .acc_strobe_o(acc_strobe), .acc_we_o(acc_we), .acc_sel_o(acc_sel),
      .acc_addr_o(acc_addr), .acc_wdata_o(acc_wdata), .soft_rst_o(soft_rst),
      .rd_valid_o(rd_valid), .rd_data_o(rd_data), .dbg_o(dbg)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // Event recorder and read-valid timing check (R5)
   always @(negedge clk) begin
      if (rst_n) begin
         if (acc_strobe) begin
            n_acc++;
            last_we = acc_we; last_sel = acc_sel;
            last_addr = acc_addr; last_wdata = acc_wdata;
         end
         if (soft_rst) n_soft++;
         if (rd_valid) begin
            n_rd++;
            last_rd = rd_data;
         end
         if (rd_valid || prev_rd_strobe) chk("R5 rd_valid timing", {31'd0, rd_valid}, {31'd0, prev_rd_strobe});
         prev_rd_strobe = acc_strobe && !acc_we;
      end
   end

   function automatic logic [31:0] model_read(logic [7:0] s, logic [7:0] a);
      if (s != 8'h01) return 32'h0;
      case (a)
         8'h00: return 32'h6672_616D;
         8'h01: return 32'h0001_0002;
         8'h10: return m_scr;
         8'h20: return {24'h0, m_dbg};
         default: return 32'h0;
      endcase
   endfunction

   // R12: gap cycles carry random bytes with the strobe low
   task automatic send_byte(logic [7:0] b);
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
         rx_valid = 1'b0; rx_byte = 8'($urandom);
         @(negedge clk);
      end
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0; rx_byte = 8'($urandom);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic do_read(logic [7:0] s, logic [7:0] a);
      int a0 = n_acc, r0 = n_rd;
      send_byte(8'h55); send_byte(8'h10); send_byte(s); send_byte(a); send_byte(8'hAA);
      settle();
      chk("R3 read access count", n_acc - a0, 1);
      chk("R3 read we", {31'd0, last_we}, 0);
      chk("R3 read sel/addr", {16'd0, last_sel, last_addr}, {16'd0, s, a});
      chk("R5 read valid count", n_rd - r0, 1);
      chk("R6 R7 R8 R11 read data", last_rd, model_read(s, a));
   endtask

   task automatic do_write(logic [7:0] s, logic [7:0] a, logic [31:0] d);
      int a0 = n_acc;
      send_byte(8'h55); send_byte(8'h11); send_byte(s); send_byte(a);
      send_byte(d[31:24]); send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
      send_byte(8'hAA);
      settle();
      chk("R4 write access count", n_acc - a0, 1);
      chk("R4 write we", {31'd0, last_we}, 1);
      chk("R4 write data MSB first", last_wdata, d);
      if (s == 8'h01 && a == 8'h10) m_scr = d;
      if (s == 8'h01 && a == 8'h20) m_dbg = d[7:0];
      chk("R8 R11 dbg output", {24'd0, dbg}, {24'd0, m_dbg});
   endtask

   task automatic do_reset();
      int s0 = n_soft, a0 = n_acc;
      send_byte(8'h55); send_byte(8'h01); send_byte(8'hAA);
      settle();
      chk("R2 soft reset pulse count", n_soft - s0, 1);
      chk("R2 no access", n_acc - a0, 0);
      m_scr = 32'h1122_3344; m_dbg = 8'h00;
      chk("R2 dbg cleared", {24'd0, dbg}, 0);
   endtask

   task automatic do_bad_end();
      int a0 = n_acc, s0 = n_soft, r0 = n_rd;
      logic [7:0] e;
      do e = 8'($urandom); while (e == 8'hAA || e == 8'h55);
      if ($urandom_range(0, 1) == 0) begin
         send_byte(8'h55); send_byte(8'h10); send_byte(8'h01); send_byte(8'h10); send_byte(e);
      end else begin
         send_byte(8'h55); send_byte(8'h01); send_byte(e);
      end
      settle();
      chk("R9 bad end no event", (n_acc - a0) + (n_soft - s0) + (n_rd - r0), 0);
   endtask

   task automatic do_bad_op();
      int a0 = n_acc, s0 = n_soft;
      logic [7:0] op;
      do op = 8'($urandom); while (op == 8'h01 || op == 8'h10 || op == 8'h11 || op == 8'h55);
      send_byte(8'h55); send_byte(op); send_byte(8'h01); send_byte(8'hAA);
      settle();
      chk("R10 unknown opcode no event", (n_acc - a0) + (n_soft - s0), 0);
   endtask

   task automatic do_junk();
      int a0 = n_acc, s0 = n_soft, r0 = n_rd;
      for (int k = 0; k < 4; k++) begin
         logic [7:0] b;
         do b = 8'($urandom); while (b == 8'h55);
         send_byte(b);
      end
      settle();
      chk("R1 idle junk no event", (n_acc - a0) + (n_soft - s0) + (n_rd - r0), 0);
   endtask

   function automatic logic [7:0] pick_addr();
      case ($urandom_range(0, 4))
         0: return 8'h00;
         1: return 8'h01;
         2: return 8'h10;
         3: return 8'h20;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R2 reset state strobe", {31'd0, acc_strobe}, 0);
      chk("R5 reset state rd_valid", {31'd0, rd_valid}, 0);
      chk("R8 reset state dbg", {24'd0, dbg}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: a full read frame with the strobe low must do nothing
      begin
         int a0 = n_acc;
         logic [7:0] fr[5] = '{8'h55, 8'h10, 8'h01, 8'h10, 8'hAA};
         foreach (fr[i]) begin rx_byte = fr[i]; @(negedge clk); end
         settle();
         chk("R12 strobe low ignored", n_acc - a0, 0);
      end

      // Directed corner cases
      do_read(8'h01, 8'h00);
      do_read(8'h01, 8'h01);
      do_read(8'h01, 8'h10);
      do_write(8'h01, 8'h10, 32'hDEAD_BEEF);
      do_read(8'h01, 8'h10);
      do_write(8'h01, 8'h20, 32'h0000_0077);
      do_read(8'h01, 8'h20);
      do_write(8'h02, 8'h10, 32'h0BAD_F00D);
      do_read(8'h01, 8'h10);
      do_read(8'h02, 8'h00);
      do_read(8'h01, 8'h33);
      do_junk();
      do_bad_end();
      do_bad_op();
      do_reset();
      do_read(8'h01, 8'h10);
      do_read(8'h01, 8'h20);

      // Constrained random mix
      for (int it = 0; it < 150; it++) begin
         logic [7:0] s = ($urandom_range(0, 3) != 0) ? 8'h01 : 8'($urandom);
         case ($urandom_range(0, 9))
            0, 1, 2: do_read(s, pick_addr());
            3, 4, 5: do_write(s, pick_addr(), $urandom);
            6:       do_reset();
            7:       do_bad_end();
            8:       do_bad_op();
            default: do_junk();
         endcase
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule